// File: doc/BRIEF.md
# Tagged DMA Command Queue

This block sits in front of a data mover that copies blocks between main memory and a local store. Software pushes commands into it. A get copies from memory into the local store, and a put copies from the local store out to memory. Each command carries a group tag and may also carry a fence flag or a barrier flag. The queue holds up to sixteen commands and hands them to the mover one at a time through a valid/done handshake. It chooses among pending commands by age and by their ordering flags.

A fence holds a command back only until the older commands with its own tag have finished. A barrier holds a command back until every older command has finished. While a barrier is queued, no younger command may start before it. Plain commands may overtake older ones that are blocked.

For each tag the block counts the commands still pending, and it reports a per-tag idle vector. A wait query takes a tag mask and reports when every tag in the mask is idle. Software uses this to rotate between buffer groups.

Top module: `dma_tag_queue`

## Requirements
- R1: `cmd_ready_o` is high exactly when fewer than DEPTH (16) commands are held. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high at a clock edge. A command offered while `cmd_ready_o` is low is dropped and is never issued.
- R2: When no transfer is in flight and at least one command is held, `xfer_valid_o` rises after the next edge. It then stays high with stable fields until an edge at which `xfer_done_i` is high. It is low in the cycle after that edge, so at most one transfer is outstanding.
- R3: A command with `cmd_fence_i` = 1 is not issued while any older command with the same tag is still held.
- R4: A command with `cmd_barrier_i` = 1 is not issued while any older command is held. No younger command is issued while an older barrier command is held.
- R5: Among the held commands that are not blocked by R3 or R4, the oldest is issued. A plain command may therefore pass an older blocked one.
- R6: `tag_idle_o[t]` is 1 exactly when no held command has tag t. After reset all 32 bits are 1. A bit clears in the cycle after a command with that tag is taken. It sets in the cycle after the done of that tag's last command.
- R7: `wait_done_o` equals `wait_req_i` AND (no bit t with `wait_mask_i[t]` = 1 and `tag_idle_o[t]` = 0). It is a combinational function of the current inputs and status.
- R8: The edge at which `xfer_done_i` completes a transfer frees its slot. If the queue was full, `cmd_ready_o` is high in the next cycle.
- R9: The issued transfer carries the direction (0 = get, 1 = put), tag, local address, memory address and length of its command unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | A slot is free |
| cmd_dir_i | input | 1 | 0 = get (memory to local), 1 = put |
| cmd_fence_i | input | 1 | Order behind older commands with the same tag |
| cmd_barrier_i | input | 1 | Order behind all older commands and ahead of all younger ones |
| cmd_tag_i | input | 5 | Tag group |
| cmd_ls_addr_i | input | 16 | Local store address |
| cmd_mem_addr_i | input | 32 | Main memory address |
| cmd_len_i | input | 16 | Transfer length |
| xfer_valid_o | output | 1 | Transfer in flight |
| xfer_dir_o | output | 1 | Direction of the transfer |
| xfer_tag_o | output | 5 | Tag of the transfer |
| xfer_ls_addr_o | output | 16 | Local store address of the transfer |
| xfer_mem_addr_o | output | 32 | Memory address of the transfer |
| xfer_len_o | output | 16 | Length of the transfer |
| xfer_done_i | input | 1 | Mover finished the current transfer |
| wait_req_i | input | 1 | Wait query active |
| wait_mask_i | input | 32 | Tags covered by the query |
| wait_done_o | output | 1 | All masked tags idle |
| tag_idle_o | output | 32 | Per-tag idle status |

## Verification
A command can be taken at the same edge at which the mover's done frees another slot. When the tags match, the per-tag counter sees an increment and a decrement together.

The bench provokes this by driving random enqueues alongside random done pulses, with tags drawn from a small range so that the tags often coincide. It also fills the queue and then releases it, so the last free slot and a refused enqueue meet a done.

Each cycle, a reference list kept in the bench, in arrival order, judges the outcome. The bench compares the ready level, the issued command's identity and fields, and the full 32-bit idle vector against that list.

// File: rtl/dma_q_pkg.sv
package dma_q_pkg;
  localparam int TAG_W    = 5;
  localparam int LS_W     = 16;
  localparam int MEM_W    = 32;
  localparam int LEN_W    = 16;
  localparam int NUM_TAGS = 1 << TAG_W;

  typedef enum logic {
    DIR_GET = 1'b0,
    DIR_PUT = 1'b1
  } dma_dir_e;

  typedef struct packed {
    dma_dir_e          dir;
    logic              fence;
    logic              barrier;
    logic [TAG_W-1:0]  tag;
    logic [LS_W-1:0]   ls_addr;
    logic [MEM_W-1:0]  mem_addr;
    logic [LEN_W-1:0]  len;
  } dma_cmd_t;
endpackage

// File: rtl/dma_q_alloc.sv
module dma_q_alloc #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] valid_i,
  output logic             any_free_o,
  output logic [IDX_W-1:0] free_idx_o
);
  // lowest free slot wins
  always_comb begin
    any_free_o = 1'b0;
    free_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free_o = 1'b1;
        free_idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_q_age_pick.sv
module dma_q_age_pick
  import dma_q_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_en_i,
  input  logic [IDX_W-1:0]            alloc_idx_i,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0]            issued_i,
  input  logic [DEPTH-1:0]            fence_i,
  input  logic [DEPTH-1:0]            barrier_i,
  input  logic [DEPTH-1:0][TAG_W-1:0] tag_i,
  output logic                        pick_valid_o,
  output logic [IDX_W-1:0]            pick_idx_o
);
  // older_q[i][j] set: slot j was allocated before slot i
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] elig;
  logic [DEPTH-1:0] win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (alloc_en_i) begin
      for (int j = 0; j < DEPTH; j++) older_q[j][alloc_idx_i] <= 1'b0;
      older_q[alloc_idx_i] <= valid_i;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DEPTH-1:0] blk;
    for (genvar j = 0; j < DEPTH; j++) begin : g_blk
      assign blk[j] = barrier_i[j] | barrier_i[i] |
                      (fence_i[i] & (tag_i[j] == tag_i[i]));
    end
    assign elig[i] = valid_i[i] & ~issued_i[i] &
                     ~|(older_q[i] & valid_i & blk);
    assign win[i]  = elig[i] & ~|(older_q[i] & elig);
  end

  always_comb begin
    pick_valid_o = |win;
    pick_idx_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (win[i]) pick_idx_o = pick_idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_q_tag_track.sv
module dma_q_tag_track
  import dma_q_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_en_i,
  input  logic [TAG_W-1:0]    inc_tag_i,
  input  logic                dec_en_i,
  input  logic [TAG_W-1:0]    dec_tag_i,
  input  logic                wait_req_i,
  input  logic [NUM_TAGS-1:0] wait_mask_i,
  output logic [NUM_TAGS-1:0] idle_o,
  output logic                wait_done_o
);
  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    logic [CNT_W-1:0] cnt_q;
    logic             inc_hit, dec_hit;
    assign inc_hit = inc_en_i & (inc_tag_i == TAG_W'(t));
    assign dec_hit = dec_en_i & (dec_tag_i == TAG_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
      end else begin
        case ({inc_hit, dec_hit})
          2'b10:   cnt_q <= cnt_q + CNT_W'(1);
          2'b01:   cnt_q <= cnt_q - CNT_W'(1);
          default: cnt_q <= cnt_q;
        endcase
      end
    end
    assign idle_o[t] = (cnt_q == '0);
  end

  assign wait_done_o = wait_req_i & ~|(wait_mask_i & ~idle_o);
endmodule

// File: rtl/dma_tag_queue.sv
module dma_tag_queue
  import dma_q_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  output logic                cmd_ready_o,
  input  logic                cmd_dir_i,
  input  logic                cmd_fence_i,
  input  logic                cmd_barrier_i,
  input  logic [TAG_W-1:0]    cmd_tag_i,
  input  logic [LS_W-1:0]     cmd_ls_addr_i,
  input  logic [MEM_W-1:0]    cmd_mem_addr_i,
  input  logic [LEN_W-1:0]    cmd_len_i,
  output logic                xfer_valid_o,
  output logic                xfer_dir_o,
  output logic [TAG_W-1:0]    xfer_tag_o,
  output logic [LS_W-1:0]     xfer_ls_addr_o,
  output logic [MEM_W-1:0]    xfer_mem_addr_o,
  output logic [LEN_W-1:0]    xfer_len_o,
  input  logic                xfer_done_i,
  input  logic                wait_req_i,
  input  logic [NUM_TAGS-1:0] wait_mask_i,
  output logic                wait_done_o,
  output logic [NUM_TAGS-1:0] tag_idle_o
);
  localparam int IDX_W = $clog2(DEPTH);

  dma_cmd_t                   ent_q [DEPTH];
  logic [DEPTH-1:0]           valid_q;
  logic                       busy_q;
  logic [IDX_W-1:0]           cur_q;
  logic                       any_free;
  logic [IDX_W-1:0]           free_idx;
  logic                       pick_valid;
  logic [IDX_W-1:0]           pick_idx;
  logic [DEPTH-1:0]           issued_vec;
  logic [DEPTH-1:0]           fence_v, barrier_v;
  logic [DEPTH-1:0][TAG_W-1:0] tag_v;
  logic                       enq_fire, done_fire, issue_fire;
  dma_cmd_t                   cmd_in, cur_cmd;

  assign cmd_in = '{dir:      dma_dir_e'(cmd_dir_i),
                    fence:    cmd_fence_i,
                    barrier:  cmd_barrier_i,
                    tag:      cmd_tag_i,
                    ls_addr:  cmd_ls_addr_i,
                    mem_addr: cmd_mem_addr_i,
                    len:      cmd_len_i};

  assign cmd_ready_o = any_free;
  assign enq_fire    = cmd_valid_i & any_free;
  assign done_fire   = busy_q & xfer_done_i;
  assign issue_fire  = ~busy_q & pick_valid;

  dma_q_alloc #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_alloc (
    .valid_i    (valid_q),
    .any_free_o (any_free),
    .free_idx_o (free_idx)
  );

  always_comb begin
    issued_vec = '0;
    if (busy_q) issued_vec[cur_q] = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      fence_v[i]   = ent_q[i].fence;
      barrier_v[i] = ent_q[i].barrier;
      tag_v[i]     = ent_q[i].tag;
    end
  end

  dma_q_age_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_en_i   (enq_fire),
    .alloc_idx_i  (free_idx),
    .valid_i      (valid_q),
    .issued_i     (issued_vec),
    .fence_i      (fence_v),
    .barrier_i    (barrier_v),
    .tag_i        (tag_v),
    .pick_valid_o (pick_valid),
    .pick_idx_o   (pick_idx)
  );

  // payload storage, no reset needed
  always_ff @(posedge clk_i) begin
    if (enq_fire) ent_q[free_idx] <= cmd_in;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
    end else begin
      if (done_fire) valid_q[cur_q] <= 1'b0;
      if (enq_fire)  valid_q[free_idx] <= 1'b1;
      if (done_fire) begin
        busy_q <= 1'b0;
      end else if (issue_fire) begin
        busy_q <= 1'b1;
        cur_q  <= pick_idx;
      end
    end
  end

  assign cur_cmd         = ent_q[cur_q];
  assign xfer_valid_o    = busy_q;
  assign xfer_dir_o      = cur_cmd.dir;
  assign xfer_tag_o      = cur_cmd.tag;
  assign xfer_ls_addr_o  = cur_cmd.ls_addr;
  assign xfer_mem_addr_o = cur_cmd.mem_addr;
  assign xfer_len_o      = cur_cmd.len;

  dma_q_tag_track #(.DEPTH(DEPTH)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .inc_en_i    (enq_fire),
    .inc_tag_i   (cmd_tag_i),
    .dec_en_i    (done_fire),
    .dec_tag_i   (cur_cmd.tag),
    .wait_req_i  (wait_req_i),
    .wait_mask_i (wait_mask_i),
    .idle_o      (tag_idle_o),
    .wait_done_o (wait_done_o)
  );
endmodule

// File: rtl/dma_tag_queue_chk.sv
module dma_tag_queue_chk
  import dma_q_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic                cmd_ready_o,
  input logic [TAG_W-1:0]    cmd_tag_i,
  input logic                xfer_valid_o,
  input logic [TAG_W-1:0]    xfer_tag_o,
  input logic [MEM_W-1:0]    xfer_mem_addr_o,
  input logic                xfer_done_i,
  input logic                wait_req_i,
  input logic [NUM_TAGS-1:0] wait_mask_i,
  input logic                wait_done_o,
  input logic [NUM_TAGS-1:0] tag_idle_o
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             acc_q;
  logic [TAG_W-1:0] acc_tag_q;
  logic             acc, dn;

  assign acc = cmd_valid_i & cmd_ready_o;
  assign dn  = xfer_valid_o & xfer_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      acc_q     <= 1'b0;
      acc_tag_q <= '0;
    end else begin
      occ_q     <= occ_q + OCC_W'(acc) - OCC_W'(dn);
      acc_q     <= acc;
      acc_tag_q <= cmd_tag_i;
    end
  end

  p_ready_occ_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o == (occ_q < OCC_W'(DEPTH)));

  p_xfer_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_done_i |=>
      xfer_valid_o && $stable(xfer_mem_addr_o) && $stable(xfer_tag_o));

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && xfer_done_i |=> !xfer_valid_o);

  p_issue_live_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_valid_o && occ_q != '0 |=> xfer_valid_o);

  p_enq_busy_tag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> !tag_idle_o[acc_tag_q]);

  p_empty_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q == '0 |-> &tag_idle_o);

  p_wait_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_done_o |-> wait_req_i && ((wait_mask_i & ~tag_idle_o) == '0));
endmodule

bind dma_tag_queue dma_tag_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_valid_i     (cmd_valid_i),
  .cmd_ready_o     (cmd_ready_o),
  .cmd_tag_i       (cmd_tag_i),
  .xfer_valid_o    (xfer_valid_o),
  .xfer_tag_o      (xfer_tag_o),
  .xfer_mem_addr_o (xfer_mem_addr_o),
  .xfer_done_i     (xfer_done_i),
  .wait_req_i      (wait_req_i),
  .wait_mask_i     (wait_mask_i),
  .wait_done_o     (wait_done_o),
  .tag_idle_o      (tag_idle_o)
);

// File: tb/sim_dma_tag_queue.sv
module sim_dma_tag_queue;
  import dma_q_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                cmd_valid_i = 1'b0, cmd_ready_o;
  logic                cmd_dir_i = 1'b0, cmd_fence_i = 1'b0, cmd_barrier_i = 1'b0;
  logic [TAG_W-1:0]    cmd_tag_i = '0;
  logic [LS_W-1:0]     cmd_ls_addr_i = '0;
  logic [MEM_W-1:0]    cmd_mem_addr_i = '0;
  logic [LEN_W-1:0]    cmd_len_i = '0;
  logic                xfer_valid_o, xfer_dir_o;
  logic [TAG_W-1:0]    xfer_tag_o;
  logic [LS_W-1:0]     xfer_ls_addr_o;
  logic [MEM_W-1:0]    xfer_mem_addr_o;
  logic [LEN_W-1:0]    xfer_len_o;
  logic                xfer_done_i = 1'b0;
  logic                wait_req_i = 1'b0;
  logic [NUM_TAGS-1:0] wait_mask_i = '0;
  logic                wait_done_o;
  logic [NUM_TAGS-1:0] tag_idle_o;

  dma_tag_queue #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_dir_i(cmd_dir_i), .cmd_fence_i(cmd_fence_i), .cmd_barrier_i(cmd_barrier_i),
    .cmd_tag_i(cmd_tag_i), .cmd_ls_addr_i(cmd_ls_addr_i),
    .cmd_mem_addr_i(cmd_mem_addr_i), .cmd_len_i(cmd_len_i),
    .xfer_valid_o(xfer_valid_o), .xfer_dir_o(xfer_dir_o), .xfer_tag_o(xfer_tag_o),
    .xfer_ls_addr_o(xfer_ls_addr_o), .xfer_mem_addr_o(xfer_mem_addr_o),
    .xfer_len_o(xfer_len_o), .xfer_done_i(xfer_done_i),
    .wait_req_i(wait_req_i), .wait_mask_i(wait_mask_i),
    .wait_done_o(wait_done_o), .tag_idle_o(tag_idle_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [TAG_W-1:0] tag;
    bit               fence;
    bit               bar;
    bit               dir;
    logic [MEM_W-1:0] id;
    logic [LS_W-1:0]  ls;
    logic [LEN_W-1:0] len;
    bit               issued;
  } mcmd_t;

  mcmd_t            mq[$];
  bit               busy_m = 0;
  bit               freed_full = 0;
  string            pick_req = "R5";
  logic [MEM_W-1:0] next_id = 32'h1000;
  int               n_chk = 0, n_bad = 0;
  bit               fin = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic int find_pick();
    for (int i = 0; i < mq.size(); i++) begin
      bit ok = !mq[i].issued;
      if (mq[i].bar && i != 0) ok = 0;
      for (int j = 0; j < i; j++) begin
        if (mq[j].bar) ok = 0;
        if (mq[i].fence && mq[j].tag == mq[i].tag) ok = 0;
      end
      if (ok) return i;
    end
    return -1;
  endfunction

  function automatic int find_inflight();
    for (int i = 0; i < mq.size(); i++) if (mq[i].issued) return i;
    return -1;
  endfunction

  function automatic logic [NUM_TAGS-1:0] exp_idle();
    logic [NUM_TAGS-1:0] v = '1;
    for (int i = 0; i < mq.size(); i++) v[mq[i].tag] = 1'b0;
    return v;
  endfunction

  task automatic step(input int enq_pct, input int done_pct, input int fence_pct,
                      input int bar_pct, input int tag_max);
    bit enq, dn, acc;
    int k, p, sz;
    logic [NUM_TAGS-1:0] ei;
    mcmd_t c;
    @(negedge clk);
    // R1 / R8: ready level
    chk(cmd_ready_o == (mq.size() < DEPTH), freed_full ? "R8" : "R1", "ready",
        64'(cmd_ready_o), 64'(mq.size() < DEPTH));
    chk(xfer_valid_o == busy_m, "R2", "xfer_valid", 64'(xfer_valid_o), 64'(busy_m));
    k = find_inflight();
    if (busy_m && xfer_valid_o && k >= 0) begin
      chk(xfer_mem_addr_o == mq[k].id, pick_req, "issued id", 64'(xfer_mem_addr_o), 64'(mq[k].id));
      chk({xfer_dir_o, xfer_tag_o, xfer_ls_addr_o, xfer_len_o} ==
          {mq[k].dir, mq[k].tag, mq[k].ls, mq[k].len}, "R9", "fields",
          64'({xfer_dir_o, xfer_tag_o, xfer_ls_addr_o, xfer_len_o}),
          64'({mq[k].dir, mq[k].tag, mq[k].ls, mq[k].len}));
    end
    ei = exp_idle();
    chk(tag_idle_o == ei, "R6", "tag_idle", 64'(tag_idle_o), 64'(ei));

    enq = ($urandom % 100) < enq_pct;
    dn  = busy_m && (($urandom % 100) < done_pct);
    c.tag    = TAG_W'($urandom % (tag_max + 1));
    c.bar    = ($urandom % 100) < bar_pct;
    c.fence  = !c.bar && (($urandom % 100) < fence_pct);
    c.dir    = $urandom % 2;
    c.id     = next_id;
    c.ls     = LS_W'($urandom);
    c.len    = LEN_W'($urandom);
    c.issued = 0;
    cmd_valid_i    = enq;
    cmd_tag_i      = c.tag;
    cmd_fence_i    = c.fence;
    cmd_barrier_i  = c.bar;
    cmd_dir_i      = c.dir;
    cmd_mem_addr_i = c.id;
    cmd_ls_addr_i  = c.ls;
    cmd_len_i      = c.len;
    xfer_done_i    = dn;
    wait_req_i     = $urandom % 2;
    wait_mask_i    = ($urandom % 2) ? NUM_TAGS'($urandom) : (NUM_TAGS'(1) << ($urandom % NUM_TAGS));
    #1;
    chk(wait_done_o == (wait_req_i && ((wait_mask_i & ~ei) == '0)), "R7", "wait_done",
        64'(wait_done_o), 64'(wait_req_i && ((wait_mask_i & ~ei) == '0)));

    // model the coming edge
    sz  = mq.size();
    acc = enq && (sz < DEPTH);
    freed_full = 0;
    if (busy_m && dn) begin
      freed_full = (sz == DEPTH) && !acc;
      if (k >= 0) mq.delete(k);
      busy_m = 0;
    end else if (!busy_m) begin
      p = find_pick();
      if (p >= 0) begin
        mq[p].issued = 1;
        busy_m = 1;
        pick_req = mq[p].bar ? "R4" : (mq[p].fence ? "R3" : "R5");
      end
    end
    if (acc) begin
      mq.push_back(c);
      next_id++;
    end
  endtask

  task automatic run(input int cycles, input int enq_pct, input int done_pct,
                     input int fence_pct, input int bar_pct, input int tag_max);
    for (int i = 0; i < cycles; i++) step(enq_pct, done_pct, fence_pct, bar_pct, tag_max);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // fill to capacity with the mover stalled, offers beyond full are refused (R1)
    run(40, 100, 0, 30, 10, 3);
    // drain: each done frees a slot (R8)
    run(60, 0, 100, 30, 10, 3);
    // dense fences and barriers on few tags (R3, R4, R5)
    run(3000, 60, 50, 30, 10, 3);
    // full tag range incl. tag 31 (R6, R7)
    run(2000, 50, 70, 40, 15, 31);
    // full queue, slow mover, two tags: enqueue meets done
    run(600, 90, 20, 50, 5, 1);
    run(120, 0, 100, 0, 0, 0);
    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule